// File: doc/BRIEF.md
# UART Transmit Framer with Line Control

This block turns one character at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one, one and a half or two stop bits at the high level. Every bit lasts a fixed number of baud ticks. The baud ticks come from a one-cycle strobe that an external divider supplies.

A character enters through a valid/ready handshake. A group of line-control inputs sets the format of the frame: the word length, the stop-bit count, whether parity is sent, even or odd parity, stick (constant) parity and forced break. These inputs are captured when a frame starts and are held for that whole frame. A change made while a frame is on the line therefore takes effect with the next character.

The break control pulls the line low at once, whatever the framer is doing. While break is set, no new character is accepted, so a character that is waiting at the input stays there unchanged. It is sent normally once break is cleared.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when no frame is in progress and `brk` is 0. `busy` is 1 from the cycle after acceptance until the end of the last stop bit.
- R3: `lc_wlen` codes 2'b00, 2'b01, 2'b10 and 2'b11 send 5, 6, 7 and 8 data bits. The bits are taken from `in_data[0]` upward, least significant bit first. Unused high bits are ignored.
- R4: The start bit is 0. The start bit, each data bit and the parity bit each last TICKS_PER_BIT (default 16) `baud_tick` pulses.
- R5: With `lc_par_en` = 0, no parity bit is sent, and the stop bit follows the last data bit directly.
- R6: With `lc_par_en` = 1 and `lc_stick` = 0, the parity bit makes the count of ones over the data bits and the parity bit even when `lc_even` = 1, and odd when `lc_even` = 0.
- R7: With `lc_par_en` = 1 and `lc_stick` = 1, the parity bit is the constant 0 when `lc_even` = 1 and the constant 1 when `lc_even` = 0.
- R8: Stop bits are 1. With `lc_two_stop` = 0 the stop period is 16 ticks. With `lc_two_stop` = 1 it is 32 ticks, except with a 5-bit word, where it is 24 ticks.
- R9: While `brk` = 1, `txd` is 0. A frame in progress keeps its timing, so its length in ticks does not change. A character waiting at the input is not accepted while break is set, and it is sent unchanged after break is cleared.
- R10: The line-control inputs are captured at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe; TICKS_PER_BIT of them make one bit time |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | `in_data` holds a character |
| in_ready | output | 1 | Framer can take a character this cycle |
| lc_wlen | input | 2 | Word-length code |
| lc_two_stop | input | 1 | Long stop period select |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Even parity select (sense inverted in stick mode) |
| lc_stick | input | 1 | Constant parity select |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |

## Verification
The bench decodes each frame at the middle of every bit and counts the total ticks of the frame. It runs every word length, and an error in the word-length decode shows up as a stop bit or a data bit in the wrong slot, or as a wrong frame length. It also covers even, odd and both stick parities, where a stick polarity that was not inverted would send mark in place of space. The 5-bit word with the long stop period must last 24 stop ticks; a design that always used two full stop bits would run 8 ticks too long. Further scenarios raise break mid-frame and change the line-control inputs mid-frame. A framer that stalled under break, or that used the new settings at once, would give a wrong tick count or wrong bits. Break is also held over a waiting character, and accepting or losing that character would show at `in_ready` or in the next frame.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       even;
    logic       stick;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } frame_state_t;

  // number of data bits for a word-length code
  function automatic logic [3:0] data_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  // parity bit value for a character under a given line setting
  function automatic logic parity_value(input logic [7:0] d, input line_cfg_t c);
    logic [7:0] mask;
    logic       ones_odd;
    mask     = 8'hFF >> (2'd3 - c.wlen);
    ones_odd = ^(d & mask);
    if (c.stick) return ~c.even;
    return c.even ? ones_odd : ~ones_odd;
  endfunction

  // length of the stop period in ticks
  function automatic int unsigned stop_ticks(input line_cfg_t c, input int unsigned tpb);
    if (!c.two_stop)       return tpb;
    if (c.wlen == 2'b00)   return tpb + tpb / 2;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/uart_txf_timer.sv
module uart_txf_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          bit_end
);
  logic [CW-1:0] cnt;

  assign bit_end = run && tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (run && tick)    cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

  // R4: the slot counter never runs past the length of the current slot
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));

endmodule

// File: rtl/uart_txf_seq.sv
module uart_txf_seq
  import uart_txf_pkg::*;
#(
  parameter int unsigned TPB = 16,
  parameter int unsigned CW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [7:0]    char_in,
  input  line_cfg_t     cfg_in,
  input  logic          bit_end,
  output logic          busy,
  output logic          line_level,
  output logic [CW-1:0] slot_limit
);
  frame_state_t state;
  line_cfg_t    cfg_q;
  logic [7:0]   shreg;
  logic [2:0]   idx;
  logic         par_q;
  logic [3:0]   nbits;
  logic         last_data;

  assign nbits     = data_bits(cfg_q.wlen);
  assign last_data = ({1'b0, idx} == nbits - 4'd1);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    if (state == ST_STOP) slot_limit = CW'(stop_ticks(cfg_q, TPB) - 1);
    else                  slot_limit = CW'(TPB - 1);
  end

  always_comb begin
    case (state)
      ST_START:  line_level = 1'b0;
      ST_DATA:   line_level = shreg[0];
      ST_PARITY: line_level = par_q;
      default:   line_level = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      shreg <= '0;
      idx   <= '0;
      par_q <= 1'b0;
    end else if (accept) begin
      state <= ST_START;
      cfg_q <= cfg_in;
      shreg <= char_in;
      idx   <= '0;
      par_q <= parity_value(char_in, cfg_in);
    end else if (bit_end) begin
      case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          shreg <= {1'b0, shreg[7:1]};
          idx   <= idx + 3'd1;
          if (last_data) state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: state <= ST_STOP;
        ST_STOP:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R10: captured line setting holds for the whole frame
  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R3: data index stays inside the selected word length
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> ({1'b0, idx} < nbits));

  // R5: no parity slot when parity is off
  a_r5_no_parity_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARITY) |-> cfg_q.par_en);

endmodule

// File: rtl/uart_txf_linedrv.sv
module uart_txf_linedrv (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic busy,
  input  logic level,
  output logic txd
);
  assign txd = brk ? 1'b0 : level;

  // R9: break always wins
  a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R1: idle line rests at mark
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] lc_wlen,
  input  logic       lc_two_stop,
  input  logic       lc_par_en,
  input  logic       lc_even,
  input  logic       lc_stick,
  input  logic       brk,
  output logic       txd,
  output logic       busy
);
  localparam int unsigned CW = $clog2(2 * TICKS_PER_BIT);

  line_cfg_t     cfg_in;
  logic          accept;
  logic          bit_end;
  logic          level;
  logic [CW-1:0] slot_limit;

  assign cfg_in   = '{wlen: lc_wlen, two_stop: lc_two_stop, par_en: lc_par_en,
                      even: lc_even, stick: lc_stick};
  assign in_ready = !busy && !brk;
  assign accept   = in_valid && in_ready;

  uart_txf_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
    .tick(baud_tick), .limit(slot_limit), .bit_end(bit_end)
  );

  uart_txf_seq #(.TPB(TICKS_PER_BIT), .CW(CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .char_in(in_data),
    .cfg_in(cfg_in), .bit_end(bit_end), .busy(busy),
    .line_level(level), .slot_limit(slot_limit)
  );

  uart_txf_linedrv drv_i (
    .clk(clk), .rst_n(rst_n), .brk(brk), .busy(busy),
    .level(level), .txd(txd)
  );

  // R2: a frame only begins after a handshake made outside break
  a_r2_start_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(in_valid) && !$past(brk)));

  // R4: first cycle of a frame shows the start bit
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

endmodule

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] lc_wlen = 2'b11;
  logic lc_two_stop = 1'b0, lc_par_en = 1'b0, lc_even = 1'b0, lc_stick = 1'b0;
  logic brk = 1'b0;
  logic txd, busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_framer #(.TICKS_PER_BIT(TPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .lc_wlen(lc_wlen),
    .lc_two_stop(lc_two_stop), .lc_par_en(lc_par_en), .lc_even(lc_even),
    .lc_stick(lc_stick), .brk(brk), .txd(txd), .busy(busy)
  );

  // tick strobe: one cycle in three
  int tdiv = 0;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 2);
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sends one character and decodes it from the line
  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic ts,
                           input logic pe, input logic ev, input logic st,
                           input bit scramble, input bit brk_mid, input string tag);
    int nb, np, stopt, exp_total, nslots, tcnt, k;
    logic exp_bits[12];
    logic par;
    nb = 5 + int'(wl);
    np = pe ? 1 : 0;
    stopt = !ts ? TPB : (wl == 2'b00 ? TPB + TPB/2 : 2*TPB);
    exp_total = TPB * (1 + nb + np) + stopt;
    par = 1'b0;
    for (int i = 0; i < nb; i++) par ^= d[i];
    if (st) par = ~ev; else if (!ev) par = ~par;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) exp_bits[1+i] = d[i];
    if (pe) exp_bits[1+nb] = par;
    exp_bits[1+nb+np] = 1'b1;
    nslots = 2 + nb + np;

    @(negedge clk);
    in_data = d; lc_wlen = wl; lc_two_stop = ts; lc_par_en = pe;
    lc_even = ev; lc_stick = st; in_valid = 1'b1; brk = 1'b0;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~d;
    if (scramble) begin
      lc_wlen = ~wl; lc_two_stop = ~ts; lc_par_en = ~pe; lc_even = ~ev; lc_stick = ~st;
    end
    check("R2", int'(busy), 1, {tag, " busy after accept"});
    check("R2", int'(in_ready), 0, {tag, " ready low in frame"});
    tcnt = 0; k = 0;
    while (busy) begin
      if (k < nslots && tcnt == TPB*k + TPB/2) begin
        if (!brk) begin
          if (k == 0)
            check("R4", int'(txd), 0, {tag, " start bit"});
          else if (k <= nb)
            check("R3", int'(txd), int'(exp_bits[k]), $sformatf("%s data bit %0d", tag, k-1));
          else if (pe && k == nb+1)
            check(st ? "R7" : "R6", int'(txd), int'(exp_bits[k]), {tag, " parity bit"});
          else
            check("R8", int'(txd), 1, {tag, " stop bit"});
        end
        k++;
      end
      if (brk_mid && tcnt == 20) brk = 1'b1;
      if (brk_mid && tcnt == 30) begin
        check("R9", int'(txd), 0, {tag, " line low in break"});
        check("R9", int'(busy), 1, {tag, " frame continues in break"});
      end
      if (brk_mid && tcnt == 40) brk = 1'b0;
      if (baud_tick) tcnt++;
      @(negedge clk);
    end
    check(pe ? "R8" : "R5", tcnt, exp_total, {tag, " frame length in ticks"});
    if (scramble) check("R10", tcnt, exp_total, {tag, " length unchanged by mid-frame edit"});
    check("R1", int'(txd), 1, {tag, " idle after frame"});
    check("R1", int'(in_ready), 1, {tag, " ready after frame"});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", int'(txd), 1, "reset txd");
    check("R1", int'(busy), 0, "reset busy");
    check("R1", int'(in_ready), 1, "reset ready");
  endtask

  task automatic t_word_lengths();
    run_frame(8'hB5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 wl5");
    run_frame(8'h6A, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 wl6");
    run_frame(8'h53, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 wl7");
    run_frame(8'hC9, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 wl8 nopar");
  endtask

  task automatic t_parity();
    run_frame(8'h17, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 even");
    run_frame(8'h17, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 odd");
    run_frame(8'hE3, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 even wl5 masked");
    run_frame(8'hFF, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 stick space");
    run_frame(8'h00, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 stick mark");
  endtask

  task automatic t_stops();
    run_frame(8'h2C, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 two stop");
    run_frame(8'h15, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 one and half");
  endtask

  task automatic t_mid_edit();
    run_frame(8'h9D, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R10 edit");
  endtask

  task automatic t_break();
    run_frame(8'hA6, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9 mid break");
    @(negedge clk);
    brk = 1'b1; in_data = 8'h4E; in_valid = 1'b1;
    lc_wlen = 2'b11; lc_two_stop = 1'b0; lc_par_en = 1'b0;
    repeat (60) @(negedge clk);
    check("R9", int'(in_ready), 0, "ready held low in break");
    check("R9", int'(busy), 0, "waiting char not taken in break");
    check("R9", int'(txd), 0, "idle line low in break");
    run_frame(8'h4E, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 after break");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_lengths();
    t_parity();
    t_stops();
    t_mid_edit();
    t_break();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=0 cycles left", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule